// File: doc/BRIEF.md
# Serial-Wire to JTAG Line Switch Generator

This block drives the shared mode/data line and the test clock of a dual-protocol debug port so that a target currently listening in serial-wire mode is moved into JTAG mode. One accepted start pulse makes it emit a fixed train of 128 test-clock periods. The train has three parts: a long run of ones that resets both protocol engines, then a 16-bit switch word shifted out least significant bit first, then a second long run of ones. The second run leaves the target's TAP in Test-Logic-Reset.

The test clock is divided down from the system clock. The line value is updated when the test clock falls and is held steady while it is high, so the target always samples a settled bit on the rising edge. A selection input picks either the current switch word (0xE73C) or the older word (0xDEAE) that some earlier targets still expect. The choice is captured when the start pulse is accepted. When the final period has finished, a one-cycle completion pulse is raised and the line is left high.

Top module: `swj_switch_top`

## Requirements
- R1: After reset, tms_o is 1, tck_o is 0, busy_o is 0 and done_o is 0. While no train is running, the block stays in that state.
- R2: A start_i seen high at a clock edge while busy_o is 0 launches exactly 128 tck_o periods. Each period is 2*HALF_DIV system clocks long, low for the first half and high for the second. The rising edge of period k (counting from 0) follows the accepting edge by 2*HALF_DIV*k + HALF_DIV clocks.
- R3: In periods 0 to 55, tms_o is 1 at every tck_o rising edge.
- R4: When legacy_i is 0 at acceptance, periods 56 to 71 carry the word 0xE73C, and period 56+j carries bit j of that word.
- R5: When legacy_i is 1 at acceptance, periods 56 to 71 carry the word 0xDEAE in the same bit order.
- R6: In periods 72 to 127, tms_o is 1 at every tck_o rising edge.
- R7: tms_o changes only on the clock edge that drives tck_o low. It never changes while tck_o is high.
- R8: done_o is high for exactly one system clock. It goes high on the edge 256*HALF_DIV clocks after the accepting edge. In that same edge busy_o drops, tck_o is 0 and tms_o is 1.
- R9: While busy_o is 1, a start_i pulse has no effect and a change on legacy_i has no effect. The running train keeps its bit pattern and its completion time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to emit the switch train |
| legacy_i | input | 1 | 1 selects the older switch word, sampled when the request is accepted |
| tck_o | output | 1 | Divided test clock |
| tms_o | output | 1 | Shared mode/data line value |
| busy_o | output | 1 | A train is in progress |
| done_o | output | 1 | One-cycle pulse when the train has finished |

## Verification
Trains are run with each of the two switch words. This tells apart a wrong word, a swapped byte order and a reversed bit order, because each of these errors shifts different positions in periods 56 to 71. Some runs put a second start pulse, together with a flip of the word selection, inside the leading ones, inside the code or inside the trailing ones. A correct block shows the word chosen at acceptance and the usual completion time. A block that restarted, re-sampled the selection or stretched the train would not. Random idle gaps between runs test that the block comes back to its quiet line state and that back-to-back requests are accepted.

// File: rtl/swj_switch_pkg.sv
package swj_switch_pkg;
  localparam int unsigned SW_CODE_W   = 16;
  localparam logic [SW_CODE_W-1:0] SW_CODE_CUR = 16'hE73C;
  localparam logic [SW_CODE_W-1:0] SW_CODE_OLD = 16'hDEAE;

  typedef enum logic [1:0] {
    SEG_LEAD = 2'd0,
    SEG_CODE = 2'd1,
    SEG_TAIL = 2'd2
  } seg_e;
endpackage

// File: rtl/swj_tck_gen.sv
module swj_tck_gen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_i,
  input  logic run_i,
  output logic tck_o,
  output logic wrap_o
);
  localparam int unsigned HALF_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(HALF_DIV - 1);

  logic [HALF_W-1:0] half_q;
  logic              tck_q;
  logic              half_end;

  assign half_end = (half_q == HALF_LAST);
  assign wrap_o   = run_i && tck_q && half_end;
  assign tck_o    = tck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= '0;
      tck_q  <= 1'b0;
    end else if (kick_i) begin
      half_q <= '0;
      tck_q  <= 1'b0;
    end else if (run_i) begin
      if (half_end) begin
        half_q <= '0;
        tck_q  <= ~tck_q;
      end else begin
        half_q <= half_q + 1'b1;
      end
    end else begin
      half_q <= '0;
      tck_q  <= 1'b0;
    end
  end

  // R2: test clock toggles only when a half period has elapsed
  a_r2_half_period: assert property (@(posedge clk) disable iff (rst)
    (run_i && !kick_i && !half_end) |=> $stable(tck_q));

  // R1: test clock is parked low when idle
  a_r1_idle_low: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !kick_i) |=> !tck_q);
endmodule

// File: rtl/swj_bit_seq.sv
module swj_bit_seq
  import swj_switch_pkg::*;
#(
  parameter int unsigned LEAD_ONES = 56,
  parameter int unsigned TAIL_ONES = 56,
  parameter bit          ALLOW_OLD = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic legacy_i,
  input  logic wrap_i,
  output logic kick_o,
  output logic busy_o,
  output logic tms_o,
  output logic done_o
);
  localparam int unsigned TOTAL = LEAD_ONES + SW_CODE_W + TAIL_ONES;
  localparam int unsigned IDX_W = $clog2(TOTAL);
  localparam logic [IDX_W-1:0] LEAD_L = IDX_W'(LEAD_ONES);
  localparam logic [IDX_W-1:0] CODE_END_L = IDX_W'(LEAD_ONES + SW_CODE_W);
  localparam logic [IDX_W-1:0] LAST_L = IDX_W'(TOTAL - 1);

  logic [IDX_W-1:0]     idx_q;
  logic [SW_CODE_W-1:0] code_q;
  logic [SW_CODE_W-1:0] code_pick;
  logic                 busy_q, tms_q, done_q;
  logic                 last_bit;
  logic [IDX_W-1:0]     idx_nxt;

  generate
    if (ALLOW_OLD) begin : g_sel
      assign code_pick = legacy_i ? SW_CODE_OLD : SW_CODE_CUR;
    end else begin : g_fixed
      assign code_pick = SW_CODE_CUR;
    end
  endgenerate

  function automatic seg_e seg_of(input logic [IDX_W-1:0] i);
    if (i < LEAD_L)          return SEG_LEAD;
    else if (i < CODE_END_L) return SEG_CODE;
    else                     return SEG_TAIL;
  endfunction

  function automatic logic bit_at(input logic [IDX_W-1:0] i,
                                  input logic [SW_CODE_W-1:0] c);
    logic [SW_CODE_W-1:0] sh;
    sh = c >> (i - LEAD_L);
    case (seg_of(i))
      SEG_CODE: return sh[0];
      default:  return 1'b1;
    endcase
  endfunction

  assign kick_o   = start_i && !busy_q;
  assign last_bit = (idx_q == LAST_L);
  assign idx_nxt  = idx_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      code_q <= SW_CODE_CUR;
      busy_q <= 1'b0;
      tms_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (kick_o) begin
        idx_q  <= '0;
        code_q <= code_pick;
        busy_q <= 1'b1;
        tms_q  <= bit_at('0, code_pick);
      end else if (busy_q && wrap_i) begin
        if (last_bit) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          tms_q  <= 1'b1;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_nxt;
          tms_q <= bit_at(idx_nxt, code_q);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign tms_o  = tms_q;
  assign done_o = done_q;

  // R9: position and selected word hold between period ends
  a_r9_hold_position: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !wrap_i) |=> ($stable(idx_q) && $stable(code_q) && busy_q));

  // R8: completion is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R8: completion only follows the final period
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> ($past(busy_q) && !busy_q));

  // R1: the line is high while idle
  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> tms_q);
endmodule

// File: rtl/swj_switch_top.sv
module swj_switch_top #(
  parameter int unsigned HALF_DIV  = 2,
  parameter int unsigned LEAD_ONES = 56,
  parameter int unsigned TAIL_ONES = 56,
  parameter bit          ALLOW_OLD = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic legacy_i,
  output logic tck_o,
  output logic tms_o,
  output logic busy_o,
  output logic done_o
);
  logic kick, wrap, busy, tck;

  swj_bit_seq #(
    .LEAD_ONES(LEAD_ONES),
    .TAIL_ONES(TAIL_ONES),
    .ALLOW_OLD(ALLOW_OLD)
  ) seq_i (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .legacy_i (legacy_i),
    .wrap_i   (wrap),
    .kick_o   (kick),
    .busy_o   (busy),
    .tms_o    (tms_o),
    .done_o   (done_o)
  );

  swj_tck_gen #(
    .HALF_DIV(HALF_DIV)
  ) tck_i (
    .clk    (clk),
    .rst    (rst),
    .kick_i (kick),
    .run_i  (busy),
    .tck_o  (tck),
    .wrap_o (wrap)
  );

  assign tck_o  = tck;
  assign busy_o = busy;

  // R7: line value is frozen while the test clock is high
  a_r7_stable_high: assert property (@(posedge clk) disable iff (rst)
    (tck && $past(tck)) |-> $stable(tms_o));

  // R7: line may change only on the edge that takes the clock low
  a_r7_change_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!$stable(tms_o) && busy) |-> !tck);

  // R8: at completion the clock is low and the line high
  a_r8_end_state: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!tck && tms_o && !busy));
endmodule

// File: tb/swj_switch_top_tb_top.sv
module swj_switch_top_tb_top;
  localparam int unsigned HALF  = 2;
  localparam int unsigned NBITS = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic legacy_i = 1'b0;
  logic tck_o, tms_o, busy_o, done_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  swj_switch_top #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .legacy_i(legacy_i),
    .tck_o(tck_o), .tms_o(tms_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_bit(input int k, input bit old);
    logic [15:0] w;
    w = old ? 16'hDEAE : 16'hE73C;
    if (k < 56 || k >= 72) return 1'b1;
    return w[k-56];
  endfunction

  function automatic logic [15:0] exp_word(input bit old);
    return old ? 16'hDEAE : 16'hE73C;
  endfunction

  // One train; disturb_at >= 0 drives a second start and a selection flip then.
  task automatic run_train(input bit old, input int disturb_at);
    bit got[NBITS];
    int nb = 0, rise_bad = 0, stab_bad = 0, done_bad = 0, done_cnt = 0;
    logic [15:0] word = '0;
    int lead_bad = 0, tail_bad = 0;
    logic ptck, ptms;
    int last_c = 256*HALF + 3;
    @(negedge clk);
    start_i = 1'b1; legacy_i = old;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    ptck = 1'b0; ptms = tms_o;
    for (int c = 0; c <= last_c; c++) begin
      if (c > 0) @(negedge clk);
      if (tck_o && !ptck) begin
        if (c != 2*HALF*nb + HALF) rise_bad++;
        if (nb < NBITS) got[nb] = tms_o;
        nb++;
      end
      if (tck_o && ptck && (tms_o !== ptms)) stab_bad++;
      if (done_o) done_cnt++;
      if (done_o !== (c == 256*HALF)) done_bad++;
      if (c == 256*HALF) begin
        chk(!busy_o && !tck_o && tms_o, "R8 end state", {busy_o, tck_o, tms_o}, 3'b001);
      end
      ptck = tck_o; ptms = tms_o;
      if (c == disturb_at) begin
        start_i = 1'b1; legacy_i = ~old;
      end else begin
        start_i = 1'b0;
      end
    end
    chk(nb == NBITS, disturb_at >= 0 ? "R9 period count" : "R2 period count", nb, NBITS);
    chk(rise_bad == 0, "R2 rise timing", rise_bad, 0);
    chk(stab_bad == 0, "R7 stable while high", stab_bad, 0);
    chk(done_bad == 0 && done_cnt == 1, disturb_at >= 0 ? "R9 done timing" : "R8 done timing",
        done_cnt, 1);
    if (nb >= NBITS) begin
      for (int k = 0; k < 56; k++) if (got[k] !== 1'b1) lead_bad++;
      for (int k = 72; k < 128; k++) if (got[k] !== 1'b1) tail_bad++;
      for (int j = 0; j < 16; j++) word[j] = got[56+j];
      chk(lead_bad == 0, "R3 lead ones", lead_bad, 0);
      chk(tail_bad == 0, "R6 tail ones", tail_bad, 0);
      if (old) chk(word == exp_word(1'b1), "R5 old word", word, exp_word(1'b1));
      else     chk(word == exp_word(1'b0), "R4 current word", word, exp_word(1'b0));
      if (exp_bit(56, old) !== got[56])
        chk(1'b0, "R4 first code bit", got[56], exp_bit(56, old));
    end
    legacy_i = 1'b0;
    chk(tms_o && !tck_o && !busy_o && !done_o, "R1 idle after train",
        {tms_o, tck_o, busy_o, done_o}, 4'b1000);
  endtask

  initial begin : main
    int gap;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tms_o === 1'b1 && tck_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0,
        "R1 reset state", {tms_o, tck_o, busy_o, done_o}, 4'b1000);
    run_train(1'b0, -1);
    run_train(1'b1, -1);
    run_train(1'b0, 10);
    run_train(1'b1, 2*HALF*60);
    run_train(1'b0, 2*HALF*100);
    run_train(1'b1, 256*HALF - 2);
    for (int r = 0; r < 12; r++) begin
      gap = $urandom_range(0, 5);
      repeat (gap) @(negedge clk);
      run_train(1'($urandom_range(0, 1)),
                ($urandom_range(0, 1) == 1) ? int'($urandom_range(1, 256*HALF - 1)) : -1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule